// File: doc/BRIEF.md
# DDR SDRAM Command Legality Monitor

This block sits passively on a DDR SDRAM command bus. On every rising clock edge it samples chip select, the three strobe lines, the bank address, A10, the low mode-field bits A2:A0 and the clock-enable level. It decodes the command, keeps a state machine for each of four banks and records the burst length from the last write of the base mode register. Any command that the addressed bank, or the device as a whole, cannot accept in its present state raises a one-cycle flag.

A flagged command leaves the tracked state untouched. Bursts are timed by counting clocks at two data beats per clock. Banks that finish an auto-precharge burst go through one precharging cycle and then return to idle by themselves. Typical uses are a protocol monitor beside a memory controller, or a scoreboard front end in a system-level bench.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With cke_i high and cs_ni low, the strobes {ras_ni,cas_ni,we_ni} decode as 111 NOP (code 0), 011 ACT (1), 101 READ (2), 100 WRITE (3), 010 PRE (4), 001 REFRESH (5), 000 MRS (6) and 110 TERMINATE (7). The code appears on cmd_o one cycle after the sampling edge.
- R2: With cs_ni high, cmd_o shows DESELECT (code 8). With cke_i low, cmd_o shows NOP. In both cases no bank changes and illegal_o stays low.
- R3: ACT is legal only to an idle bank, which then becomes row active. ACT to any other bank is flagged.
- R4: READ or WRITE is legal to a bank that is row active, reading or writing, unless an auto-precharge burst is running. A10 high selects the auto-precharge variant. Every other case is flagged.
- R5: REFRESH and MRS are flagged unless all four banks are idle.
- R6: For MRS, BA 00 selects the base register and BA 01 the extended one. BA with bit 1 set is flagged. A base write whose A2:A0 is not 1, 2 or 3 is flagged. A legal base write sets the burst length to 2, 4 or 8. After reset the length is 4.
- R7: After a legal READ or WRITE, burst_active_o is high for exactly BL/2 cycles. When it drops, a plain burst leaves the bank row active.
- R8: A legal READ or WRITE during a plain burst restarts the count. It returns the bank that was bursting to row active.
- R9: TERMINATE is flagged to an idle, precharging, writing or auto-precharge bank. It is a no-op to a row-active bank. To a reading bank it ends the burst and returns the bank to row active.
- R10: PRE with A10 high targets all banks; with A10 low it targets the BA bank. An idle target stays idle. Any other target precharges for exactly one cycle, then becomes idle, and its burst ends.
- R11: When an auto-precharge burst ends, its bank precharges for one cycle and then becomes idle with no further command.
- R12: After reset all banks are idle, cmd_o is NOP, and illegal_o and burst_active_o are low. illegal_o is high for exactly the one cycle after each offending command. A flagged command changes no state. Bank i reports on bank_state_o[3i+2:3i] with codes idle 0, row active 1, reading 2, writing 3, reading with auto-precharge 4, writing with auto-precharge 5, precharging 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock-enable level; low masks the command |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Auto-precharge / precharge-all select |
| mode_i | input | 3 | Address bits A2:A0, burst length field of MRS |
| cmd_o | output | 4 | Decoded command code of the previous edge |
| bank_state_o | output | 12 | Three-bit state per bank |
| illegal_o | output | 1 | One-cycle flag for an offending command |
| burst_active_o | output | 1 | A data burst is in progress |

## Verification
A behavioural reference model in the bench steps alongside the design and is compared on every clock. Directed sequences come first. They use lone commands to idle and active banks to separate the bank-state rules from the device-wide REFRESH and MRS rules. Back-to-back READ and WRITE to different banks show whether interruption returns the earlier bank to row active. TERMINATE and PRE aimed at reading, writing and idle banks tell apart the three terminate outcomes and single-bank precharge from precharge-all. Burst lengths 2, 4 and 8 expose off-by-one errors in the beat count. A long random command stream then mixes deselects, masked cycles and bank conflicts.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_ACT   = 4'd1,
    CMD_READ  = 4'd2,
    CMD_WRITE = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_REF   = 4'd5,
    CMD_MRS   = 4'd6,
    CMD_TERM  = 4'd7,
    CMD_DESEL = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE     = 3'd0,
    BK_ACTIVE   = 3'd1,
    BK_READ     = 3'd2,
    BK_WRITE    = 3'd3,
    BK_READ_AP  = 3'd4,
    BK_WRITE_AP = 3'd5,
    BK_PRECHG   = 3'd6
  } bank_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (!cke_i) cmd_o = CMD_NOP;
    else if (cs_ni) cmd_o = CMD_DESEL;
    else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_READ;
        3'b100:  cmd_o = CMD_WRITE;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_TERM;
      endcase
    end
  end
endmodule

// File: rtl/ddr_legal_check.sv
module ddr_legal_check
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int MODE_W    = 3,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  cmd_e                        cmd_i,
  input  logic [BA_W-1:0]             ba_i,
  input  logic [MODE_W-1:0]           mode_i,
  input  bank_e [NUM_BANKS-1:0]       st_i,
  input  logic                        ap_run_i,
  output logic                        illegal_o
);
  logic  all_idle;
  bank_e tgt;

  assign tgt = st_i[ba_i];

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++)
      if (st_i[i] != BK_IDLE) all_idle = 1'b0;
  end

  always_comb begin
    illegal_o = 1'b0;
    case (cmd_i)
      CMD_ACT:   illegal_o = (tgt != BK_IDLE);
      CMD_READ,
      CMD_WRITE: illegal_o = ap_run_i || !(tgt inside {BK_ACTIVE, BK_READ, BK_WRITE});
      CMD_TERM:  illegal_o = !(tgt inside {BK_ACTIVE, BK_READ});
      CMD_REF:   illegal_o = !all_idle;
      CMD_MRS:   illegal_o = !all_idle || (ba_i[BA_W-1:1] != '0) ||
                             ((ba_i == '0) && !(mode_i inside {MODE_W'(1), MODE_W'(2), MODE_W'(3)}));
      default:   illegal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_mon_pkg::*;
#(
  parameter int BA_W = 2,
  parameter int IDX  = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cmd_e            cmd_i,       // already masked when illegal
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  input  logic            owner_end_i,
  output bank_e           state_o
);
  bank_e st_q, st_d;
  logic  sel;

  assign sel = (ba_i == BA_W'(IDX));

  always_comb begin
    st_d = st_q;
    if (st_q == BK_PRECHG) st_d = BK_IDLE;
    else if (owner_end_i)
      st_d = (st_q inside {BK_READ_AP, BK_WRITE_AP}) ? BK_PRECHG : BK_ACTIVE;
    case (cmd_i)
      CMD_ACT:   if (sel) st_d = BK_ACTIVE;
      CMD_READ:  if (sel) st_d = a10_i ? BK_READ_AP : BK_READ;
      CMD_WRITE: if (sel) st_d = a10_i ? BK_WRITE_AP : BK_WRITE;
      CMD_TERM:  if (sel && st_q == BK_READ) st_d = BK_ACTIVE;
      CMD_PRE:   if (sel || a10_i)
                   st_d = (st_q inside {BK_IDLE, BK_PRECHG}) ? BK_IDLE : BK_PRECHG;
      default:   ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= BK_IDLE;
    else         st_q <= st_d;

  assign state_o = st_q;

  AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == BK_IDLE |=> st_q inside {BK_IDLE, BK_ACTIVE}); // R3
  AST_PRECHG_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == BK_PRECHG |=> st_q == BK_IDLE); // R10
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int MODE_W    = 3,
  parameter logic [MODE_W-1:0] MODE_RST = 3'd2,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int ST_W     = $bits(bank_e),
  localparam int MAX_CODE = 3,
  localparam int MAX_CLK  = (1 << MAX_CODE) / 2,
  localparam int BST_W    = $clog2(MAX_CLK + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cke_i,
  input  logic                      cs_ni,
  input  logic                      ras_ni,
  input  logic                      cas_ni,
  input  logic                      we_ni,
  input  logic [BA_W-1:0]           ba_i,
  input  logic                      a10_i,
  input  logic [MODE_W-1:0]         mode_i,
  output logic [3:0]                cmd_o,
  output logic [NUM_BANKS*ST_W-1:0] bank_state_o,
  output logic                      illegal_o,
  output logic                      burst_active_o
);
  cmd_e                  cmd, cmd_ok, cmd_q;
  bank_e [NUM_BANKS-1:0] st;
  logic [NUM_BANKS-1:0]  own_end;
  logic [MODE_W-1:0]     bl_q;
  logic [BST_W-1:0]      cnt_q, burst_clks;
  logic [BA_W-1:0]       own_q;
  logic                  illegal, ill_q, ap_run, new_burst, stop_burst;

  ddr_cmd_decode u_dec (
    .cke_i (cke_i), .cs_ni (cs_ni), .ras_ni (ras_ni),
    .cas_ni(cas_ni), .we_ni (we_ni), .cmd_o (cmd)
  );

  assign ap_run = (cnt_q != '0) && (st[own_q] inside {BK_READ_AP, BK_WRITE_AP});

  ddr_legal_check #(.NUM_BANKS(NUM_BANKS), .MODE_W(MODE_W)) u_chk (
    .cmd_i (cmd), .ba_i (ba_i), .mode_i (mode_i),
    .st_i  (st),  .ap_run_i (ap_run), .illegal_o (illegal)
  );

  assign cmd_ok     = illegal ? CMD_NOP : cmd;
  assign new_burst  = cmd_ok inside {CMD_READ, CMD_WRITE};
  assign stop_burst = ((cmd_ok == CMD_PRE) && (a10_i || ba_i == own_q)) ||
                      ((cmd_ok == CMD_TERM) && (ba_i == own_q));
  // two beats per clock: BL/2 clocks
  assign burst_clks = BST_W'(1) << (bl_q - MODE_W'(1));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign own_end[i] = (cnt_q != '0) && (own_q == BA_W'(i)) &&
                        ((cnt_q == BST_W'(1)) || (new_burst && ba_i != own_q));
    ddr_bank_fsm #(.BA_W(BA_W), .IDX(i)) u_bank (
      .clk_i (clk_i), .rst_ni (rst_ni), .cmd_i (cmd_ok), .ba_i (ba_i),
      .a10_i (a10_i), .owner_end_i (own_end[i]), .state_o (st[i])
    );
    assign bank_state_o[i*ST_W +: ST_W] = st[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      own_q <= '0;
      bl_q  <= MODE_RST;
      cmd_q <= CMD_NOP;
      ill_q <= 1'b0;
    end else begin
      cmd_q <= cmd;
      ill_q <= illegal;
      if (new_burst) begin
        cnt_q <= burst_clks;
        own_q <= ba_i;
      end else if (stop_burst) cnt_q <= '0;
      else if (cnt_q != '0)    cnt_q <= cnt_q - BST_W'(1);
      if (cmd_ok == CMD_MRS && ba_i == '0) bl_q <= mode_i;
    end
  end

  assign cmd_o          = cmd_q;
  assign illegal_o      = ill_q;
  assign burst_active_o = (cnt_q != '0);

  AST_BURST_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0 |-> st[own_q] inside {BK_READ, BK_WRITE, BK_READ_AP, BK_WRITE_AP}); // R7
  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cs_ni) |=> (!illegal_o && cmd_o == CMD_DESEL)); // R2
  AST_REF_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && !cs_ni && {ras_ni, cas_ni, we_ni} == 3'b001 && bank_state_o != '0)
      |=> illegal_o); // R5
  AST_MRS_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && !cs_ni && {ras_ni, cas_ni, we_ni} == 3'b000 && ba_i[BA_W-1])
      |=> illegal_o); // R6
endmodule

// File: tb/tb_ddr_cmd_monitor.sv
module tb_ddr_cmd_monitor;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4,
                 C_REF = 5, C_MRS = 6, C_TERM = 7, C_DESEL = 8;
  localparam int S_IDLE = 0, S_ACT = 1, S_RD = 2, S_WR = 3, S_RAP = 4,
                 S_WAP = 5, S_PRE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [2:0] mo = '0;
  logic [3:0] cmd_o;
  logic [11:0] bank_state_o;
  logic illegal_o, burst_active_o;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R12";

  int m_st[4] = '{0, 0, 0, 0};
  int m_cnt = 0, m_own = 0, m_bl = 2, m_cmd = 0;
  bit m_ill = 0;

  ddr_cmd_monitor dut (
    .clk_i (clk), .rst_ni (rst_n), .cke_i (cke), .cs_ni (cs_n),
    .ras_ni (ras_n), .cas_ni (cas_n), .we_ni (we_n), .ba_i (ba),
    .a10_i (a10), .mode_i (mo), .cmd_o (cmd_o), .bank_state_o (bank_state_o),
    .illegal_o (illegal_o), .burst_active_o (burst_active_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_ap(input int s);
    return s == S_RAP || s == S_WAP;
  endfunction

  task automatic model_step();
    int c, b, s, nc;
    int nx[4];
    bit ill, all_idle, ap_run;
    b = int'(ba);
    if (!cke) c = C_NOP;
    else if (cs_n) c = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111: c = C_NOP;   3'b011: c = C_ACT;
        3'b101: c = C_RD;    3'b100: c = C_WR;
        3'b010: c = C_PRE;   3'b001: c = C_REF;
        3'b000: c = C_MRS;   default: c = C_TERM;
      endcase
    end
    s = m_st[b];
    all_idle = 1;
    for (int i = 0; i < 4; i++) if (m_st[i] != S_IDLE) all_idle = 0;
    ap_run = (m_cnt > 0) && is_ap(m_st[m_own]);
    ill = 0;
    case (c)
      C_ACT:      ill = (s != S_IDLE);
      C_RD, C_WR: ill = ap_run || !(s == S_ACT || s == S_RD || s == S_WR);
      C_TERM:     ill = !(s == S_ACT || s == S_RD);
      C_REF:      ill = !all_idle;
      C_MRS:      ill = !all_idle || b >= 2 || (b == 0 && (mo < 1 || mo > 3));
      default:    ill = 0;
    endcase
    for (int i = 0; i < 4; i++) nx[i] = (m_st[i] == S_PRE) ? S_IDLE : m_st[i];
    if (m_cnt == 1) nx[m_own] = is_ap(m_st[m_own]) ? S_PRE : S_ACT;
    nc = (m_cnt > 0) ? m_cnt - 1 : 0;
    if (!ill) begin
      case (c)
        C_ACT: nx[b] = S_ACT;
        C_RD, C_WR: begin
          if (m_cnt > 0 && m_own != b) nx[m_own] = S_ACT;
          if (c == C_RD) nx[b] = a10 ? S_RAP : S_RD;
          else           nx[b] = a10 ? S_WAP : S_WR;
          nc = 1 << (m_bl - 1);
          m_own = b;
        end
        C_PRE:
          for (int i = 0; i < 4; i++)
            if (a10 || i == b) begin
              nx[i] = (m_st[i] == S_IDLE || m_st[i] == S_PRE) ? S_IDLE : S_PRE;
              if (m_cnt > 0 && i == m_own) nc = 0;
            end
        C_TERM: begin
          if (s == S_RD) nx[b] = S_ACT;
          if (m_cnt > 0 && m_own == b) nc = 0;
        end
        C_MRS: if (b == 0) m_bl = int'(mo);
        default: ;
      endcase
    end
    for (int i = 0; i < 4; i++) m_st[i] = nx[i];
    m_cnt = nc;
    m_cmd = c;
    m_ill = ill;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_st[i] = S_IDLE;
      m_cnt = 0; m_own = 0; m_bl = 2; m_cmd = C_NOP; m_ill = 0;
    end else model_step();
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [11:0] exp_st;
      for (int i = 0; i < 4; i++) exp_st[i*3 +: 3] = 3'(m_st[i]);
      chk(cmd_o == 4'(m_cmd), cur_req, "cmd_o", 32'(cmd_o), 32'(m_cmd));
      chk(illegal_o == m_ill, cur_req, "illegal_o", 32'(illegal_o), 32'(m_ill));
      chk(burst_active_o == (m_cnt > 0), cur_req, "burst_active_o",
          32'(burst_active_o), 32'(m_cnt > 0));
      chk(bank_state_o == exp_st, cur_req, "bank_state_o", 32'(bank_state_o), 32'(exp_st));
    end
  end

  task automatic issue(input int c, input int b, input bit ap, input int m);
    @(negedge clk);
    cke = 1'b1; cs_n = (c == C_DESEL);
    ba = 2'(b); a10 = ap; mo = 3'(m);
    case (c)
      C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      C_RD:    {ras_n, cas_n, we_n} = 3'b101;
      C_WR:    {ras_n, cas_n, we_n} = 3'b100;
      C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      C_REF:   {ras_n, cas_n, we_n} = 3'b001;
      C_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      C_TERM:  {ras_n, cas_n, we_n} = 3'b110;
      C_DESEL: {ras_n, cas_n, we_n} = 3'b011;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) issue(C_NOP, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset values
    chk(cmd_o == 4'd0 && bank_state_o == '0 && !illegal_o && !burst_active_o,
        "R12", "reset outputs", {cmd_o, bank_state_o, illegal_o, burst_active_o}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R1";
    issue(C_ACT, 0, 0, 0); issue(C_RD, 0, 0, 0); idle(3);
    issue(C_WR, 0, 0, 0); idle(3); issue(C_TERM, 0, 0, 0);
    issue(C_PRE, 0, 0, 0); idle(2); issue(C_REF, 0, 0, 0);
    issue(C_MRS, 0, 0, 2); idle(2);

    cur_req = "R2";
    issue(C_DESEL, 1, 0, 0);
    @(negedge clk); cke = 1'b0; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b011;
    idle(2);

    cur_req = "R3";
    issue(C_ACT, 1, 0, 0); issue(C_ACT, 1, 0, 0); idle(2);

    cur_req = "R4";
    issue(C_RD, 2, 0, 0); issue(C_RD, 1, 1, 0); issue(C_RD, 1, 0, 0);
    issue(C_WR, 1, 0, 0); idle(4);

    cur_req = "R5";
    issue(C_ACT, 0, 0, 0); issue(C_REF, 0, 0, 0); issue(C_MRS, 0, 0, 1);
    issue(C_PRE, 0, 1, 0); idle(2); issue(C_REF, 0, 0, 0); idle(1);

    cur_req = "R6";
    issue(C_MRS, 1, 0, 5); issue(C_MRS, 2, 0, 1); issue(C_MRS, 3, 0, 1);
    issue(C_MRS, 0, 0, 0); issue(C_MRS, 0, 0, 3); idle(1);

    cur_req = "R7";
    issue(C_ACT, 2, 0, 0); idle(1); issue(C_RD, 2, 0, 0); idle(6);
    issue(C_WR, 2, 0, 0); idle(6);

    cur_req = "R8";
    issue(C_ACT, 3, 0, 0); issue(C_RD, 2, 0, 0); issue(C_RD, 3, 0, 0);
    issue(C_WR, 2, 0, 0); idle(6);

    cur_req = "R9";
    issue(C_TERM, 1, 0, 0); issue(C_WR, 2, 0, 0); issue(C_TERM, 2, 0, 0);
    idle(5); issue(C_RD, 2, 0, 0); idle(1); issue(C_TERM, 2, 0, 0);
    idle(2); issue(C_TERM, 3, 0, 0); idle(1);

    cur_req = "R10";
    issue(C_RD, 3, 0, 0); issue(C_PRE, 3, 0, 0); idle(2);
    issue(C_PRE, 3, 0, 0); issue(C_PRE, 0, 1, 0); idle(3);

    cur_req = "R11";
    issue(C_MRS, 0, 0, 1); issue(C_ACT, 0, 0, 0); issue(C_WR, 0, 1, 0); idle(4);
    issue(C_ACT, 1, 0, 0); issue(C_RD, 1, 1, 0); idle(4);

    cur_req = "R12";
    for (int k = 0; k < 600; k++) begin
      issue(int'($urandom_range(0, 8)), int'($urandom_range(0, 3)),
            ($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)));
      if ($urandom_range(0, 9) == 0) cke = 1'b0;
    end
    idle(4);
    finish_run();
  end
endmodule